// File: doc/BRIEF.md
# DMA Completion Interrupt and Chaining Unit

This block turns transfer-request completion reports into CPU interrupts and chained trigger requests. Two report ports feed it: one fires when a request is handed to the data mover (submit), the other fires when the data of a request has finished moving (done). Each report carries the 32-bit option word of the request and a flag that says whether the request was the last of its parameter set. A mode bit in the option word chooses which of the two ports counts as completion for that request.

A recognised completion may set one bit, chosen by the 6-bit completion code, in a 64-bit pending register, in a 64-bit chained register, or in both. Final and intermediate completions each have their own interrupt enable and chaining enable. Software sets and clears pending bits and enable bits through a single write port with write-one semantics. The CPU interrupt is a level: it is high while any pending bit has its enable bit set. Chained bits are drained one channel per cycle as single-cycle trigger pulses to the request generator, and each pulse clears its bit.

Top module: `dma_cmpl_intc`

## Requirements
- R1: After reset the pending, enable and chained registers are zero, `cpu_irq` is 0 and `chain_trig_vld` is 0.
- R2: The option word is decoded as follows: bit 11 selects early mode when 1, bits 17:12 hold the completion code, bit 20 enables the final interrupt, bit 21 the intermediate interrupt, bit 22 final chaining and bit 23 intermediate chaining; all other bits have no effect.
- R3: A recognised completion with `last`=1 and bit 20 set sets pending bit [code] at the next clock edge; with `last`=0, bit 20 alone sets nothing.
- R4: A recognised completion with `last`=0 and bit 21 set sets pending bit [code]; with `last`=1, bit 21 alone sets nothing.
- R5: Chained bit [code] is set by bit 22 on a final completion and by bit 23 on an intermediate completion, at the next clock edge; with neither port active no chained bit rises.
- R6: A report on the submit port counts only when its bit 11 is 1; a report on the done port counts only when its bit 11 is 0; a report on the other port leaves every register unchanged.
- R7: A write with `wr_sel` 0 sets the pending bits where `wr_data` is 1, 1 clears those pending bits, 2 sets those enable bits, 3 clears those enable bits; selectors 4 to 7 change nothing.
- R8: When a completion sets a pending bit in the same cycle that a software write clears it, the bit ends up set.
- R9: `cpu_irq` is 1 exactly when some bit is 1 in both the pending and enable registers.
- R10: While the chained register is non-zero, `chain_trig_vld` is 1 and `chain_trig_ch` is the lowest set index; that bit clears at the next edge unless a completion sets it again in the same cycle.
- R11: Reports on both ports in the same cycle are both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_vld | input | 1 | Submit report valid |
| sub_opt | input | 32 | Option word of the submitted request |
| sub_last | input | 1 | Submitted request is the last of its set |
| done_vld | input | 1 | Data-done report valid |
| done_opt | input | 32 | Option word of the finished request |
| done_last | input | 1 | Finished request is the last of its set |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 pend set, 1 pend clear, 2 enable set, 3 enable clear |
| wr_data | input | 64 | Write-one mask |
| pend_q | output | 64 | Pending register |
| en_q | output | 64 | Enable register |
| chain_q | output | 64 | Chained register |
| cpu_irq | output | 1 | Level interrupt to the CPU |
| chain_trig_vld | output | 1 | Trigger pulse to the request generator |
| chain_trig_ch | output | 6 | Channel of the trigger pulse |

## Verification
The clear-register property assumes that no completion report arrives in the cycle of the clear, since a report could legitimately re-set the bit; the bench still mixes reports with clears, and the property simply does not look at those cycles. The stability properties assume the write port and both report ports are quiet, which the random stimulus produces often by keeping each strobe active only part of the time. Completion codes are drawn from a small set so that set/clear collisions and repeated chain sets on one channel occur often.

// File: rtl/dma_cmpl_pkg.sv
package dma_cmpl_pkg;

    localparam int CODE_W          = 6;
    localparam int NCH             = 1 << CODE_W;
    localparam int OPT_W           = 32;
    localparam int OPT_EARLY_BIT   = 11;
    localparam int OPT_CODE_LSB    = 12;
    localparam int OPT_FIN_INT_BIT = 20;
    localparam int OPT_MID_INT_BIT = 21;
    localparam int OPT_FIN_CHN_BIT = 22;
    localparam int OPT_MID_CHN_BIT = 23;
    localparam int SEL_W           = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_PEND_SET = 3'd0,
        SEL_PEND_CLR = 3'd1,
        SEL_EN_SET   = 3'd2,
        SEL_EN_CLR   = 3'd3
    } reg_sel_e;

    typedef struct packed {
        logic              early;
        logic [CODE_W-1:0] code;
        logic              fin_int;
        logic              mid_int;
        logic              fin_chn;
        logic              mid_chn;
    } cmpl_ctl_t;

    function automatic cmpl_ctl_t decode_opt(input logic [OPT_W-1:0] opt);
        cmpl_ctl_t c;
        c.early   = opt[OPT_EARLY_BIT];
        c.code    = opt[OPT_CODE_LSB +: CODE_W];
        c.fin_int = opt[OPT_FIN_INT_BIT];
        c.mid_int = opt[OPT_MID_INT_BIT];
        c.fin_chn = opt[OPT_FIN_CHN_BIT];
        c.mid_chn = opt[OPT_MID_CHN_BIT];
        return c;
    endfunction

    function automatic logic [NCH-1:0] code_mask(input logic [CODE_W-1:0] code);
        logic [NCH-1:0] m;
        m       = '0;
        m[code] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dma_cmpl_route.sv
module dma_cmpl_route
    import dma_cmpl_pkg::*;
#(
    parameter bit EARLY_SRC = 1'b0
) (
    input  logic             vld,
    input  logic [OPT_W-1:0] opt,
    input  logic             last,
    output logic [NCH-1:0]   pend_set,
    output logic [NCH-1:0]   chn_set
);
    cmpl_ctl_t ctl;
    logic      take;
    logic      pend_hit;
    logic      chn_hit;
    logic      unused_opt_bits;

    assign ctl             = decode_opt(opt);
    assign unused_opt_bits = ^{opt[OPT_EARLY_BIT-1:0], opt[OPT_FIN_INT_BIT-1:OPT_CODE_LSB+CODE_W],
                               opt[OPT_W-1:OPT_MID_CHN_BIT+1]};

    always_comb begin
        take     = vld && (ctl.early == EARLY_SRC);
        pend_hit = take && (last ? ctl.fin_int : ctl.mid_int);
        chn_hit  = take && (last ? ctl.fin_chn : ctl.mid_chn);
        pend_set = pend_hit ? code_mask(ctl.code) : '0;
        chn_set  = chn_hit  ? code_mask(ctl.code) : '0;
    end

endmodule

// File: rtl/dma_cmpl_intreg.sv
module dma_cmpl_intreg
    import dma_cmpl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   hw_set,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NCH-1:0]   wr_data,
    output logic [NCH-1:0]   pend_q,
    output logic [NCH-1:0]   en_q,
    output logic             irq
);
    logic [NCH-1:0] p_set, p_clr, e_set, e_clr;
    reg_sel_e       sel;

    always_comb begin
        sel   = reg_sel_e'(wr_sel);
        p_set = hw_set;
        p_clr = '0;
        e_set = '0;
        e_clr = '0;
        if (wr_en) begin
            case (sel)
                SEL_PEND_SET: p_set = hw_set | wr_data;
                SEL_PEND_CLR: p_clr = wr_data;
                SEL_EN_SET:   e_set = wr_data;
                SEL_EN_CLR:   e_clr = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~p_clr) | p_set;
            en_q   <= (en_q & ~e_clr) | e_set;
        end
    end

    assign irq = |(pend_q & en_q);

endmodule

// File: rtl/dma_cmpl_chain.sv
module dma_cmpl_chain
    import dma_cmpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    set,
    output logic [NCH-1:0]    chain_q,
    output logic              trig_vld,
    output logic [CODE_W-1:0] trig_ch
);
    logic [NCH-1:0] consume;

    always_comb begin
        trig_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chain_q[i]) trig_ch = CODE_W'(i);
        end
        trig_vld = |chain_q;
        consume  = trig_vld ? code_mask(trig_ch) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= (chain_q & ~consume) | set;
    end

endmodule

// File: rtl/dma_cmpl_intc.sv
module dma_cmpl_intc
    import dma_cmpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sub_vld,
    input  logic [OPT_W-1:0]  sub_opt,
    input  logic              sub_last,
    input  logic              done_vld,
    input  logic [OPT_W-1:0]  done_opt,
    input  logic              done_last,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [NCH-1:0]    wr_data,
    output logic [NCH-1:0]    pend_q,
    output logic [NCH-1:0]    en_q,
    output logic [NCH-1:0]    chain_q,
    output logic              cpu_irq,
    output logic              chain_trig_vld,
    output logic [CODE_W-1:0] chain_trig_ch
);
    localparam int NSRC = 2;

    logic [NSRC-1:0]             src_vld, src_last;
    logic [NSRC-1:0][OPT_W-1:0]  src_opt;
    logic [NSRC-1:0][NCH-1:0]    src_pend, src_chn;
    logic [NCH-1:0]              pend_set_all, chn_set_all;

    assign src_vld  = {sub_vld, done_vld};
    assign src_last = {sub_last, done_last};
    assign src_opt  = {sub_opt, done_opt};

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            dma_cmpl_route #(.EARLY_SRC(g == 1)) u_route (
                .vld      (src_vld[g]),
                .opt      (src_opt[g]),
                .last     (src_last[g]),
                .pend_set (src_pend[g]),
                .chn_set  (src_chn[g])
            );
        end
    endgenerate

    always_comb begin
        pend_set_all = '0;
        chn_set_all  = '0;
        for (int s = 0; s < NSRC; s++) begin
            pend_set_all |= src_pend[s];
            chn_set_all  |= src_chn[s];
        end
    end

    dma_cmpl_intreg u_intreg (
        .clk     (clk),
        .rst     (rst),
        .hw_set  (pend_set_all),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .irq     (cpu_irq)
    );

    dma_cmpl_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .set      (chn_set_all),
        .chain_q  (chain_q),
        .trig_vld (chain_trig_vld),
        .trig_ch  (chain_trig_ch)
    );

endmodule

// File: rtl/dma_cmpl_intc_chk.sv
module dma_cmpl_intc_chk
    import dma_cmpl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sub_vld,
    input logic              done_vld,
    input logic              wr_en,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [NCH-1:0]    wr_data,
    input logic [NCH-1:0]    pend_q,
    input logic [NCH-1:0]    en_q,
    input logic [NCH-1:0]    chain_q,
    input logic              cpu_irq,
    input logic              chain_trig_vld,
    input logic [CODE_W-1:0] chain_trig_ch
);
    AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (pend_q != '0) && (en_q != '0)); // R9

    AST_TRIG_ON_SET_BIT: assert property (@(posedge clk) disable iff (rst)
        chain_trig_vld |-> chain_q[chain_trig_ch]); // R10

    AST_TRIG_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !chain_trig_vld |-> (chain_q == '0)); // R10

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd1 && !sub_vld && !done_vld) |=> ((pend_q & $past(wr_data)) == '0)); // R7

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !sub_vld && !done_vld) |=> ($stable(pend_q) && $stable(en_q))); // R7

    AST_CHAIN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!sub_vld && !done_vld) |=> ((chain_q & ~$past(chain_q)) == '0)); // R5

endmodule

bind dma_cmpl_intc dma_cmpl_intc_chk u_chk (.*);

// File: tb/dma_cmpl_intc_bench.sv
`timescale 1ns/1ps
module dma_cmpl_intc_bench;
    import dma_cmpl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sub_vld = 0, sub_last = 0, done_vld = 0, done_last = 0, wr_en = 0;
    logic [31:0] sub_opt = '0, done_opt = '0;
    logic [2:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] pend_q, en_q, chain_q;
    logic        cpu_irq, chain_trig_vld;
    logic [5:0]  chain_trig_ch;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [63:0] m_pend, m_en, m_chain;

    always #2.5 clk = ~clk;

    dma_cmpl_intc u_dma_cmpl_intc (.*);

    function automatic logic [31:0] mk_opt(bit early, int code, bit fi, bit mi, bit fc, bit mc);
        logic [31:0] o;
        o = '0;
        o[11] = early; o[17:12] = code[5:0];
        o[20] = fi; o[21] = mi; o[22] = fc; o[23] = mc;
        return o;
    endfunction

    function automatic logic [63:0] hit(bit v, logic [31:0] o, bit last, bit early_port, bit chn);
        logic [63:0] m;
        bit en;
        m = '0;
        if (chn) en = last ? o[22] : o[23];
        else     en = last ? o[20] : o[21];
        if (v && (o[11] == early_port) && en) m[o[17:12]] = 1'b1;
        return m;
    endfunction

    function automatic int lowest(logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " pend"}, pend_q, m_pend);
        chk({tag, " en"}, en_q, m_en);
        chk({tag, " chain"}, chain_q, m_chain);
        chk({tag, " irq R9"}, 64'(cpu_irq), 64'(|(m_pend & m_en)));
        chk({tag, " trig_vld R10"}, 64'(chain_trig_vld), 64'(m_chain != 0));
        if (m_chain != 0) chk({tag, " trig_ch R10"}, 64'(chain_trig_ch), 64'(lowest(m_chain)));
    endtask

    // inputs are driven 1 ns after a rising edge; model advances, edge, then check
    task automatic step(string tag);
        logic [63:0] hp, hc, ps, pc, es, ec, cons;
        hp = hit(sub_vld, sub_opt, sub_last, 1, 0) | hit(done_vld, done_opt, done_last, 0, 0);
        hc = hit(sub_vld, sub_opt, sub_last, 1, 1) | hit(done_vld, done_opt, done_last, 0, 1);
        ps = (wr_en && wr_sel == 0) ? wr_data : '0;
        pc = (wr_en && wr_sel == 1) ? wr_data : '0;
        es = (wr_en && wr_sel == 2) ? wr_data : '0;
        ec = (wr_en && wr_sel == 3) ? wr_data : '0;
        cons = '0;
        if (m_chain != 0) cons[lowest(m_chain)] = 1'b1;
        m_pend  = (m_pend & ~pc) | ps | hp;
        m_en    = (m_en & ~ec) | es;
        m_chain = (m_chain & ~cons) | hc;
        @(posedge clk); #1;
        sub_vld = 0; done_vld = 0; wr_en = 0;
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        m_pend = '0; m_en = '0; m_chain = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check_all("R1 reset");

        // R3 final interrupt on done port
        done_vld = 1; done_last = 1; done_opt = mk_opt(0, 5, 1, 0, 0, 0); step("R3 final");
        done_vld = 1; done_last = 0; done_opt = mk_opt(0, 6, 1, 0, 0, 0); step("R3 mid ignored");
        // R4 intermediate interrupt
        done_vld = 1; done_last = 0; done_opt = mk_opt(0, 7, 0, 1, 0, 0); step("R4 mid");
        done_vld = 1; done_last = 1; done_opt = mk_opt(0, 8, 0, 1, 0, 0); step("R4 final ignored");
        // R6 mode/port mismatch ignored
        sub_vld = 1; sub_last = 1; sub_opt = mk_opt(0, 10, 1, 1, 1, 1); step("R6 normal on submit");
        done_vld = 1; done_last = 1; done_opt = mk_opt(1, 11, 1, 1, 1, 1); step("R6 early on done");
        // R2 top code, early, plus noise bits
        sub_vld = 1; sub_last = 1; sub_opt = mk_opt(1, 63, 1, 0, 0, 0) | 32'hFF0C_07FF & ~32'h0000_0800 | 32'h0000_0800;
        step("R2 code 63 early");
        // R7 enable + R9 irq
        wr_en = 1; wr_sel = 2; wr_data = 64'h1 << 5; step("R7 en set R9");
        wr_en = 1; wr_sel = 5; wr_data = '1; step("R7 bad sel");
        wr_en = 1; wr_sel = 1; wr_data = 64'h1 << 5; step("R7 pend clr");
        wr_en = 1; wr_sel = 0; wr_data = 64'h1 << 5; step("R7 pend set");
        wr_en = 1; wr_sel = 3; wr_data = 64'h1 << 5; step("R7 en clr");
        // R8 set wins
        wr_en = 1; wr_sel = 1; wr_data = 64'h1 << 9;
        done_vld = 1; done_last = 1; done_opt = mk_opt(0, 9, 1, 0, 0, 0); step("R8 set wins");
        // R5, R11, R10
        sub_vld = 1; sub_last = 1; sub_opt = mk_opt(1, 7, 0, 0, 1, 0);
        done_vld = 1; done_last = 0; done_opt = mk_opt(0, 3, 0, 0, 0, 1); step("R5 R11 chain both");
        step("R10 drain first");
        step("R10 drain second");
        // R10 re-set of channel being drained
        done_vld = 1; done_last = 1; done_opt = mk_opt(0, 4, 0, 0, 1, 0); step("R10 set");
        done_vld = 1; done_last = 1; done_opt = mk_opt(0, 4, 0, 0, 1, 0); step("R10 reset wins");
        step("R10 drain");

        for (int n = 0; n < 3000; n++) begin
            int codes[4] = '{0, 9, 33, 63};
            sub_vld  = ($urandom % 3) == 0;
            sub_last = $urandom % 2;
            sub_opt  = $urandom | mk_opt($urandom % 2, codes[$urandom % 4], 0, 0, 0, 0);
            sub_opt[17:12] = 6'(codes[$urandom % 4]);
            done_vld  = ($urandom % 3) == 0;
            done_last = $urandom % 2;
            done_opt  = $urandom;
            done_opt[17:12] = 6'(codes[$urandom % 4]);
            wr_en   = ($urandom % 4) == 0;
            wr_sel  = 3'($urandom);
            wr_data = {$urandom, $urandom};
            step("R11 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule